// File: doc/BRIEF.md
# Watchdog / Alarm Countdown Timer

This block is a down counter, three bytes wide by default, with a seed register behind it. It runs in one of two modes. In periodic mode it counts whole seconds, raises an alarm flag each time the count runs out, reloads itself from the seed and keeps going. In one-shot mode it counts the fast 4096 Hz tick and stops at zero. While running in one-shot mode, software or a strobe pin must restart it before it reaches zero, so it works as a watchdog. When it expires with the interrupt routed, it drives an interrupt pulse of fixed length that cannot be cut short.

The host reaches the counter one byte at a time through byte-select read and write strobes. A separate flag write strobe clears the alarm flag. The configuration bits come in as plain level inputs. The block derives its own seconds rate from the fast tick with a local prescaler. Because the prescaler is local, loading the counter also restarts the seconds phase. With the run input low, the counter stands still and its bytes act as ordinary storage.

Top module: `wdt_alarm_timer`

## Requirements
- R1: A write of a counter byte (select 0 = bits 7:0, 1 = bits 15:8, 2 = bits 23:16; select 3 touches nothing) loads that byte into the seed and loads the counter with the updated seed. It also restarts the seconds phase, so the next periodic decrement comes SEC_DIV fast ticks after the write.
- R2: With run high and the one-shot input low, the counter decrements once every SEC_DIV fast ticks. On the step from 1, the alarm flag sets, the counter reloads from the seed and counting continues.
- R3: With run high and the one-shot input high, the counter decrements on every fast tick. On the step from 1, the alarm flag sets and the counter stays at 0.
- R4: In one-shot mode, the counter reloads from the seed on a rising edge of the strobe input, or on a counter-byte read made while the strobe is low. A strobe held high or low, and a read made while the strobe is high, do not reload it.
- R5: With run low, the counter does not change and the alarm flag does not set. Bytes written read back unchanged on the next cycle.
- R6: With run high and a seed of all zeros, the counter never counts and the alarm flag never sets.
- R7: A one-shot expiry with the interrupt enable high and the interrupt routing input high drives irq_n low for exactly PULSE_TICKS fast ticks. A clear of the flag during the pulse is ignored. At the end of the pulse the flag clears and irq_n returns high.
- R8: In periodic mode, with the interrupt enable and routing inputs both high, irq_n stays low for as long as the alarm flag is set.
- R9: A flag write with data 0 clears the alarm flag. A flag write with data 1 leaves it unchanged.
- R10: While running, reading byte 0 captures all counter bits. Reads of bytes 1 and 2 return that captured value while the counter keeps counting.
- R11: With the interrupt enable or routing input low, the alarm flag still sets but irq_n stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fast | input | 1 | One-cycle enable at 4096 Hz |
| wd_strobe | input | 1 | Watchdog strobe, already synchronous |
| ctl_run | input | 1 | 1 = counter runs, 0 = storage mode |
| ctl_oneshot | input | 1 | 1 = one-shot fast mode, 0 = periodic seconds mode |
| ctl_irq_route | input | 1 | 1 = alarm drives irq_n |
| ctl_irq_en | input | 1 | Alarm interrupt enable |
| reg_wr | input | 1 | Counter byte write strobe |
| reg_rd | input | 1 | Counter byte read strobe |
| reg_sel | input | SEL_W | Byte select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| flag_wr | input | 1 | Alarm flag write strobe |
| flag_wdata | input | 1 | Alarm flag write value |
| alarm_flag | output | 1 | Alarm flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The count itself is hidden, so a wrong count, seed or prescaler phase shows up first as the alarm flag rising in the wrong cycle. In periodic mode that is up to one second of fast ticks later. Through the read port the error shows the cycle after a byte-0 read. A wrong pulse counter shows as irq_n releasing too early or too late, together with the self-clearing flag. Because of this, the bench compares alarm_flag, irq_n and reg_rdata against its model on every cycle, and uses directed reads to expose the captured bytes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    MODE_PERIODIC = 1'b0,
    MODE_ONESHOT  = 1'b1
  } wdt_mode_e;

  function automatic logic [7:0] pick_byte(input logic [31:0] v, input logic [1:0] s);
    return v[8*s +: 8];
  endfunction
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int SEC_DIV = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clr,
  output logic sec_step
);
  localparam int PW = (SEC_DIV > 1) ? $clog2(SEC_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(SEC_DIV - 1);

  logic [PW-1:0] phase;

  assign sec_step = tick && (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)   phase <= '0;
    else if (tick)    phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (phase == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int NBYTES = 3,
  parameter int SEL_W  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  wdt_mode_e       mode,
  input  logic            tick,
  input  logic            sec_step,
  input  logic            strobe,
  input  logic            wr,
  input  logic            rd,
  input  logic [SEL_W-1:0] sel,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  output logic            expire,
  output logic            phase_clr
);
  localparam int CW = NBYTES * 8;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt, seed, snap, seed_nx;
  logic strobe_q;
  logic wr_hit, rd_hit, rise, restart, step, oneshot;

  assign oneshot = (mode == MODE_ONESHOT);
  assign wr_hit  = wr && (int'(sel) < NBYTES);
  assign rd_hit  = rd && (int'(sel) < NBYTES);
  assign rise    = strobe && !strobe_q;
  assign restart = run && oneshot && ((rd_hit && !strobe) || rise);
  assign step    = run && (cnt != '0) && (oneshot ? tick : sec_step);
  assign expire  = step && (cnt == ONE) && !wr_hit && !restart;
  assign phase_clr = wr_hit || restart || !run;

  always_comb begin
    seed_nx = seed;
    for (int b = 0; b < NBYTES; b++)
      if (wr_hit && int'(sel) == b) seed_nx[8*b +: 8] = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      seed     <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe;
      seed     <= seed_nx;
      if (wr_hit)        cnt <= seed_nx;
      else if (restart)  cnt <= seed;
      else if (step)     cnt <= (cnt == ONE && !oneshot) ? seed : cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap  <= '0;
      rdata <= '0;
    end else if (rd_hit) begin
      if (!run) begin
        rdata <= seed[8*sel +: 8];
      end else if (sel == '0) begin
        snap  <= cnt;
        rdata <= cnt[7:0];
      end else begin
        rdata <= snap[8*sel +: 8];
      end
    end
  end

  // R2
  no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && !restart && !(cnt == ONE && !oneshot)) |=> (cnt <= $past(cnt)));
  // R3
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (run && oneshot && cnt == '0 && !wr_hit && !restart) |=> (cnt == '0));
  // R5
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_hit) |=> $stable(cnt));
endmodule

// File: rtl/wdt_irq.sv
module wdt_irq #(
  parameter int PULSE_TICKS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic oneshot,
  input  logic route,
  input  logic en,
  input  logic tick,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic af,
  output logic irq_n
);
  localparam int PTW = $clog2(PULSE_TICKS + 1);
  localparam logic [PTW-1:0] PLAST = PTW'(PULSE_TICKS - 1);

  logic pulse, pulse_n, af_n, start, pend;
  logic [PTW-1:0] pcnt;

  assign pend  = pulse && tick && (pcnt == PLAST);
  assign start = expire && oneshot && route && en;

  always_comb begin
    af_n = af;
    if (expire)                                   af_n = 1'b1;
    else if (pend)                                af_n = 1'b0;
    else if (flag_wr && !flag_wdata && !pulse)    af_n = 1'b0;
    pulse_n = pulse;
    if (start)      pulse_n = 1'b1;
    else if (pend)  pulse_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      af    <= 1'b0;
      pulse <= 1'b0;
      pcnt  <= '0;
      irq_n <= 1'b1;
    end else begin
      af    <= af_n;
      pulse <= pulse_n;
      if (start)               pcnt <= '0;
      else if (pulse && tick)  pcnt <= pcnt + 1'b1;
      irq_n <= !(pulse_n || (route && en && !oneshot && af_n));
    end
  end

  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse) |-> ($past(pcnt) == PLAST));
  // R7
  pulse_end_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse) |-> !af);
  // R9
  no_set_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && flag_wdata && !expire && !af) |=> !af);
  // R8
  level_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (af && $past(route && en && !oneshot)) |-> !irq_n);
endmodule

// File: rtl/wdt_alarm_timer.sv
module wdt_alarm_timer
  import wdt_pkg::*;
#(
  parameter int NBYTES      = 3,
  parameter int SEL_W       = 2,
  parameter int SEC_DIV     = 4096,
  parameter int PULSE_TICKS = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_fast,
  input  logic             wd_strobe,
  input  logic             ctl_run,
  input  logic             ctl_oneshot,
  input  logic             ctl_irq_route,
  input  logic             ctl_irq_en,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  output logic             alarm_flag,
  output logic             irq_n
);
  logic sec_step, expire, phase_clr;
  wdt_mode_e mode;

  assign mode = ctl_oneshot ? MODE_ONESHOT : MODE_PERIODIC;

  wdt_prescale #(.SEC_DIV(SEC_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick(tick_fast), .clr(phase_clr), .sec_step(sec_step)
  );

  wdt_counter #(.NBYTES(NBYTES), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst(rst), .run(ctl_run), .mode(mode), .tick(tick_fast),
    .sec_step(sec_step), .strobe(wd_strobe), .wr(reg_wr), .rd(reg_rd),
    .sel(reg_sel), .wdata(reg_wdata), .rdata(reg_rdata), .expire(expire),
    .phase_clr(phase_clr)
  );

  wdt_irq #(.PULSE_TICKS(PULSE_TICKS)) u_irq (
    .clk(clk), .rst(rst), .expire(expire), .oneshot(ctl_oneshot),
    .route(ctl_irq_route), .en(ctl_irq_en), .tick(tick_fast),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .af(alarm_flag), .irq_n(irq_n)
  );

  // R5
  storage_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_run && !alarm_flag) |=> !alarm_flag);
endmodule

// File: tb/sim_wdt_alarm_timer.sv
module sim_wdt_alarm_timer;
  localparam int SEC = 8;
  localparam int PT  = 16;

  logic clk = 0, rst = 1, tick_fast = 0, wd_strobe = 0;
  logic ctl_run = 0, ctl_oneshot = 0, ctl_irq_route = 0, ctl_irq_en = 0;
  logic reg_wr = 0, reg_rd = 0, flag_wr = 0, flag_wdata = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic alarm_flag, irq_n;

  int checks = 0, errors = 0, cyc = 0, tph = 0;
  string phase = "reset";
  bit cmp_on = 0;

  wdt_alarm_timer #(.SEC_DIV(SEC), .PULSE_TICKS(PT)) u0 (.*);

  always #2 clk = ~clk;

  // behavioural reference model
  int m_cnt, m_seed, m_pre, m_snap, m_rd, m_pt;
  bit m_sq, m_af, m_pulse, m_irqn;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_seed = 0; m_pre = 0; m_snap = 0; m_rd = 0; m_pt = 0;
      m_sq = 0; m_af = 0; m_pulse = 0; m_irqn = 1;
    end else begin
      bit wr, rd, restart, step, expire, pend, start;
      int nseed;
      wr = reg_wr && reg_sel < 3;
      rd = reg_rd && reg_sel < 3;
      restart = ctl_run && ctl_oneshot && ((rd && !wd_strobe) || (wd_strobe && !m_sq));
      nseed = wr ? ((m_seed & ~(255 << (8*reg_sel))) | (int'(reg_wdata) << (8*reg_sel))) : m_seed;
      step = ctl_run && m_cnt != 0 && (ctl_oneshot ? tick_fast : (tick_fast && m_pre == SEC-1));
      expire = step && m_cnt == 1 && !wr && !restart;
      if (rd) begin
        if (!ctl_run) m_rd = (m_seed >> (8*reg_sel)) & 255;
        else if (reg_sel == 0) begin m_snap = m_cnt; m_rd = m_cnt & 255; end
        else m_rd = (m_snap >> (8*reg_sel)) & 255;
      end
      if (wr) m_cnt = nseed;
      else if (restart) m_cnt = m_seed;
      else if (step) m_cnt = (m_cnt == 1 && !ctl_oneshot) ? m_seed : m_cnt - 1;
      m_seed = nseed;
      if (wr || restart || !ctl_run) m_pre = 0;
      else if (tick_fast) m_pre = (m_pre + 1) % SEC;
      m_sq = wd_strobe;
      pend = m_pulse && tick_fast && m_pt == PT-1;
      start = expire && ctl_oneshot && ctl_irq_route && ctl_irq_en;
      if (expire) m_af = 1;
      else if (pend) m_af = 0;
      else if (flag_wr && !flag_wdata && !m_pulse) m_af = 0;
      if (start) begin m_pulse = 1; m_pt = 0; end
      else begin
        if (m_pulse && tick_fast) m_pt++;
        if (pend) m_pulse = 0;
      end
      m_irqn = !(m_pulse || (ctl_irq_route && ctl_irq_en && !ctl_oneshot && m_af));
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tph = (tph + 1) % 2;
    tick_fast = (tph == 0);
    if (cmp_on) begin
      chk({phase, " flag"}, alarm_flag, m_af);
      chk({phase, " irq_n"}, irq_n, m_irqn);
      chk({phase, " rdata"}, reg_rdata, m_rd);
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic wr_byte(int s, int d);
    @(negedge clk); reg_sel = 2'(s); reg_wdata = 8'(d); reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd_byte(int s, output int v);
    @(negedge clk); reg_sel = 2'(s); reg_rd = 1;
    @(negedge clk); reg_rd = 0; v = reg_rdata;
  endtask
  task automatic flag_put(bit d);
    @(negedge clk); flag_wdata = d; flag_wr = 1;
    @(negedge clk); flag_wr = 0;
  endtask
  task automatic seed3(int v);
    wr_byte(2, (v >> 16) & 255); wr_byte(1, (v >> 8) & 255); wr_byte(0, v & 255);
  endtask

  initial begin
    int v;
    idle(3); rst = 0; idle(1); cmp_on = 1;
    chk("reset flag", alarm_flag, 0);
    chk("reset irq_n", irq_n, 1);

    phase = "R5";
    wr_byte(0, 8'h11); wr_byte(1, 8'h22); wr_byte(2, 8'h33); idle(60);
    rd_byte(0, v); chk("R5 byte0", v, 8'h11);
    rd_byte(1, v); chk("R5 byte1", v, 8'h22);
    rd_byte(2, v); chk("R5 byte2", v, 8'h33);
    chk("R5 flag", alarm_flag, 0);

    phase = "R1";
    ctl_run = 1; ctl_irq_route = 1; ctl_irq_en = 1;
    seed3(2); idle(26); wr_byte(0, 2); idle(26);
    chk("R1 phase restart", alarm_flag, 0);
    idle(10); chk("R1 after full period", alarm_flag, 1);

    phase = "R8";
    chk("R8 level irq", irq_n, 0);
    phase = "R9";
    flag_put(1); idle(1); chk("R9 write one", alarm_flag, 1);
    flag_put(0); chk("R9 write zero", alarm_flag, 0);
    chk("R8 released", irq_n, 1);

    phase = "R2";
    seed3(3); flag_put(0); idle(100); chk("R2 periodic", alarm_flag, 1);
    flag_put(0); idle(40); chk("R2 reloaded", alarm_flag, 1);

    phase = "R10";
    ctl_irq_en = 0; seed3(256); flag_put(0);
    rd_byte(0, v); chk("R10 low", v, 0);
    idle(20);
    rd_byte(1, v); chk("R10 captured high", v, 1);
    rd_byte(0, v); chk("R10 new low", v, 255);
    rd_byte(1, v); chk("R10 new high", v, 0);

    phase = "R7";
    ctl_oneshot = 1; ctl_irq_en = 1; seed3(20); flag_put(0); idle(45);
    chk("R7 flag", alarm_flag, 1); chk("R7 pulse", irq_n, 0);
    flag_put(0); idle(2); chk("R7 clear ignored", alarm_flag, 1);
    idle(40); chk("R7 self clear", alarm_flag, 0); chk("R7 release", irq_n, 1);
    phase = "R3";
    rd_byte(0, v); chk("R3 stopped at zero", v, 0);

    phase = "R4";
    ctl_irq_en = 0; seed3(30);
    for (int i = 0; i < 8; i++) begin
      idle(30); @(negedge clk); wd_strobe = 1; @(negedge clk); wd_strobe = 0;
    end
    chk("R4 edge kicks", alarm_flag, 0);
    @(negedge clk); wd_strobe = 1; idle(90);
    chk("R4 steady high", alarm_flag, 1);
    wd_strobe = 0; flag_put(0); rd_byte(0, v);
    for (int i = 0; i < 6; i++) begin idle(30); rd_byte(1, v); end
    chk("R4 read kicks", alarm_flag, 0);
    @(negedge clk); wd_strobe = 1;
    for (int i = 0; i < 5; i++) begin idle(30); rd_byte(0, v); end
    chk("R4 read with strobe high", alarm_flag, 1);
    wd_strobe = 0;

    phase = "R6";
    ctl_oneshot = 0; seed3(0); flag_put(0); idle(200);
    chk("R6 zero seed", alarm_flag, 0);

    phase = "R11";
    ctl_irq_en = 1; ctl_irq_route = 0; seed3(2); idle(50);
    chk("R11 flag", alarm_flag, 1); chk("R11 no irq", irq_n, 1);
    ctl_irq_route = 1; ctl_irq_en = 0; ctl_oneshot = 1; seed3(5); flag_put(0); idle(20);
    chk("R11 oneshot flag", alarm_flag, 1); chk("R11 oneshot no irq", irq_n, 1);

    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog: got 0 expected 1 (run finished)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule